// File: doc/BRIEF.md
# Radio Data Block Synchronization Tracker

This block decides whether a radio data receiver is aligned to the 26-bit block structure of the incoming data stream. An upstream checker presents one result per received block on a single-cycle strobe: the 3-bit code of the offset word it found (or a flag saying none was found) and a bit saying the block could not be corrected. From that stream the tracker acquires synchronization, keeps a flywheel position that predicts the next offset word, and drops synchronization when too many blocks in a row fail.

Acquisition has two programmable rules (two of three blocks in order, or two consecutive blocks in order). The loss rule is also programmable: a failing block is either one whose offset word is not the predicted one, or one marked uncorrectable, and the run length that causes loss is picked from an eight-entry table. A synchronous clear input forces the unsynchronized state. All outputs are registered and change only in the clock cycle after a block strobe or a clear.

The controller has four states. HUNT holds no reference. CONF1 holds one reference block and a predicted next position. CONF2 holds a reference followed by one missing block (acquisition rule 0 only). LOCK is synchronized. The transitions are: seed (HUNT to CONF1 on any usable offset word), confirm (CONF1 or CONF2 to LOCK on the predicted offset), reseed (CONF1 or CONF2 to CONF1 on a usable but unpredicted offset), gap (CONF1 to CONF2 on an unusable block under rule 0), drop (CONF1 under rule 1, or CONF2, to HUNT on an unusable block), flywheel (LOCK to LOCK), loss (LOCK to HUNT when the failure run reaches the limit), and clear (any state to HUNT while `sync_clear` is high).

Top module: `rds_sync_tracker`

## Requirements
- R1: Offset codes are decoded as A=000 (position 0), B=001 (position 1), C=010 and C'=011 (both position 2), D=100 (position 3). Codes 110 and 111, and any block with `blk_found`=0, count as no usable offset word.
- R2: Code 101 (E) is treated as no offset when `cfg_rbds`=0. When `cfg_rbds`=1 it matches whatever position is predicted in CONF1, CONF2 and LOCK, but it cannot seed from HUNT.
- R3: With `cfg_acq_mode`=0, a reference block followed by one unusable block and then the predicted offset gives LOCK; two unusable blocks after the reference return to HUNT.
- R4: With `cfg_acq_mode`=1, the predicted offset must arrive in the block directly after the reference; an unusable block there returns to HUNT.
- R5: During acquisition, a usable offset that is not the predicted one becomes the new reference, and the prediction becomes its position plus one (modulo 4).
- R6: `lock_pulse` is high for exactly one cycle, in the cycle after the block that moves the tracker into LOCK, and at no other time.
- R7: The failure-run limit is selected by `cfg_loss_code` read as a number: 0→3, 1→4, 2→5, 3→6, 4→8, 5→10, 6→12, 7→16 blocks. Loss happens on the block that makes the run equal to the limit.
- R8: With `cfg_loss_mode`=0, a block in LOCK fails when its offset is not the predicted one (after R1 and R2 decoding).
- R9: With `cfg_loss_mode`=1, a block in LOCK fails only when `blk_uncorr`=1; offset order is then irrelevant.
- R10: Any passing block in LOCK clears the failure run.
- R11: While `sync_clear` is high, the tracker goes to HUNT and strobed blocks are ignored.
- R12: `locked` and `next_offset` change only in the cycle after a strobe or a clear. In LOCK the prediction advances one position per block. `next_offset` gives the predicted offset code (C shown as 010) and is 000 in HUNT.
- R13: After `rst_n` is released: `locked`=0, `next_offset`=000, `lock_pulse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clear | input | 1 | Synchronous force to the unsynchronized state |
| blk_valid | input | 1 | One-cycle strobe per received block |
| blk_offset | input | 3 | Offset word code found in the block |
| blk_found | input | 1 | An offset word was found |
| blk_uncorr | input | 1 | The block could not be corrected |
| cfg_rbds | input | 1 | 1: offset E is recognised |
| cfg_acq_mode | input | 1 | 0: two of three in order; 1: two consecutive in order |
| cfg_loss_mode | input | 1 | 0: fail on wrong order; 1: fail on uncorrectable |
| cfg_loss_code | input | 3 | Failure-run limit selector |
| locked | output | 1 | Synchronized, as of the last block |
| next_offset | output | 3 | Predicted offset code of the next block |
| lock_pulse | output | 1 | One-cycle pulse when synchronization is established |

## Verification
The assertion on the failure counter assumes that `cfg_loss_code` does not shrink below the current run while the tracker is locked. The stimulus therefore changes the loss limit and mode only when the failure run is zero: in HUNT, or right after a passing block. The hold assertions assume that configuration changes cannot move the outputs on their own, and they cannot, because the outputs depend only on registered state. Strobes are issued at most every other cycle, and the clear is never raised on a cycle where a result is expected.

// File: rtl/rds_sync_pkg.sv
package rds_sync_pkg;

    typedef enum logic [1:0] {
        S_HUNT  = 2'd0,
        S_CONF1 = 2'd1,
        S_CONF2 = 2'd2,
        S_LOCK  = 2'd3
    } trk_state_t;

    localparam int POS_W  = 2;
    localparam int CODE_W = 3;

    // failure-run limit selected by the 3-bit loss code
    function automatic int unsigned loss_limit(input logic [CODE_W-1:0] code);
        int unsigned lim;
        case (code)
            3'd0:    lim = 3;
            3'd1:    lim = 4;
            3'd2:    lim = 5;
            3'd3:    lim = 6;
            3'd4:    lim = 8;
            3'd5:    lim = 10;
            3'd6:    lim = 12;
            default: lim = 16;
        endcase
        return lim;
    endfunction

    // predicted position to the offset code shown to the outside
    function automatic logic [CODE_W-1:0] pos_to_code(input logic [POS_W-1:0] p);
        logic [CODE_W-1:0] c;
        case (p)
            2'd0:    c = 3'b000;
            2'd1:    c = 3'b001;
            2'd2:    c = 3'b010;
            default: c = 3'b100;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rds_offset_classify.sv
module rds_offset_classify
    import rds_sync_pkg::*;
(
    input  logic [CODE_W-1:0] off_code,
    input  logic              off_found,
    input  logic              rbds_en,
    output logic              ref_ok,
    output logic [POS_W-1:0]  ref_pos,
    output logic              wild_ok
);

    always_comb begin
        ref_ok  = 1'b0;
        ref_pos = '0;
        wild_ok = 1'b0;
        if (off_found) begin
            case (off_code)
                3'b000: begin ref_ok = 1'b1; ref_pos = 2'd0; end
                3'b001: begin ref_ok = 1'b1; ref_pos = 2'd1; end
                3'b010,
                3'b011: begin ref_ok = 1'b1; ref_pos = 2'd2; end
                3'b100: begin ref_ok = 1'b1; ref_pos = 2'd3; end
                3'b101: wild_ok = rbds_en;
                default: ;
            endcase
        end
    end

    always_comb begin
        a_r1_exclusive: assert (!(ref_ok && wild_ok));
    end

endmodule

// File: rtl/rds_loss_counter.sv
module rds_loss_counter
    import rds_sync_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic              fail,
    input  logic [CODE_W-1:0] limit_code,
    output logic              loss
);

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(loss_limit(limit_code));
    assign loss  = step && fail && (run_cnt == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clr) begin
            run_cnt <= '0;
        end else if (step) begin
            if (!fail || loss) begin
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    a_r7_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < limit);

    a_r10_pass_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !fail && !clr) |=> (run_cnt == '0));

endmodule

// File: rtl/rds_sync_tracker.sv
module rds_sync_tracker
    import rds_sync_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clear,
    input  logic              blk_valid,
    input  logic [CODE_W-1:0] blk_offset,
    input  logic              blk_found,
    input  logic              blk_uncorr,
    input  logic              cfg_rbds,
    input  logic              cfg_acq_mode,
    input  logic              cfg_loss_mode,
    input  logic [CODE_W-1:0] cfg_loss_code,
    output logic              locked,
    output logic [CODE_W-1:0] next_offset,
    output logic              lock_pulse
);

    trk_state_t       state, state_nx;
    logic [POS_W-1:0] exp_pos, exp_nx;
    logic             ref_ok, wild_ok, hit, take, fail, loss;
    logic [POS_W-1:0] ref_pos;
    logic             locked_q, pulse_q;

    rds_offset_classify u_classify (
        .off_code  (blk_offset),
        .off_found (blk_found),
        .rbds_en   (cfg_rbds),
        .ref_ok    (ref_ok),
        .ref_pos   (ref_pos),
        .wild_ok   (wild_ok)
    );

    assign take = blk_valid && !sync_clear;
    assign hit  = (ref_ok && (ref_pos == exp_pos)) || wild_ok;
    assign fail = cfg_loss_mode ? blk_uncorr : !hit;

    rds_loss_counter #(.CNT_W(CNT_W)) u_loss (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (sync_clear || (state != S_LOCK)),
        .step       (take && (state == S_LOCK)),
        .fail       (fail),
        .limit_code (cfg_loss_code),
        .loss       (loss)
    );

    // next-state decision for one strobed block
    always_comb begin
        state_nx = state;
        exp_nx   = exp_pos;
        unique case (state)
            S_HUNT: begin
                if (ref_ok) begin
                    state_nx = S_CONF1;
                    exp_nx   = ref_pos + 2'd1;
                end
            end
            S_CONF1: begin
                if (hit) begin
                    state_nx = S_LOCK;
                    exp_nx   = exp_pos + 2'd1;
                end else if (ref_ok) begin
                    state_nx = S_CONF1;
                    exp_nx   = ref_pos + 2'd1;
                end else if (!cfg_acq_mode) begin
                    state_nx = S_CONF2;
                    exp_nx   = exp_pos + 2'd1;
                end else begin
                    state_nx = S_HUNT;
                    exp_nx   = '0;
                end
            end
            S_CONF2: begin
                if (hit) begin
                    state_nx = S_LOCK;
                    exp_nx   = exp_pos + 2'd1;
                end else if (ref_ok) begin
                    state_nx = S_CONF1;
                    exp_nx   = ref_pos + 2'd1;
                end else begin
                    state_nx = S_HUNT;
                    exp_nx   = '0;
                end
            end
            S_LOCK: begin
                if (loss) begin
                    state_nx = S_HUNT;
                    exp_nx   = '0;
                end else begin
                    exp_nx   = exp_pos + 2'd1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_HUNT;
            exp_pos <= '0;
        end else if (sync_clear) begin
            state   <= S_HUNT;
            exp_pos <= '0;
        end else if (take) begin
            state   <= state_nx;
            exp_pos <= exp_nx;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else if (sync_clear) begin
            locked_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q <= take && (state != S_LOCK) && (state_nx == S_LOCK);
            if (take) begin
                locked_q <= (state_nx == S_LOCK);
            end
        end
    end

    assign locked      = locked_q;
    assign lock_pulse  = pulse_q;
    assign next_offset = (state == S_HUNT) ? 3'b000 : pos_to_code(exp_pos);

    a_r6_pulse_locked: assert property (@(posedge clk) disable iff (!rst_n)
        lock_pulse |-> locked);

    a_r6_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> lock_pulse);

    a_r11_clear_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clear |=> (!locked && (next_offset == 3'b000) && !lock_pulse));

    a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_valid && !sync_clear) |=> ($stable(locked) && $stable(next_offset) && !lock_pulse));

    a_r12_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (next_offset == 3'b000) || (next_offset == 3'b001) ||
        (next_offset == 3'b010) || (next_offset == 3'b100));

    a_r3_no_gap_rule1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_acq_mode |-> (state != S_CONF2) || $past(!cfg_acq_mode));

endmodule

// File: tb/rds_sync_tracker_test.sv
`timescale 1ns/1ps
module rds_sync_tracker_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_clear = 1'b0;
    logic       blk_valid = 1'b0;
    logic [2:0] blk_offset = 3'b000;
    logic       blk_found = 1'b0;
    logic       blk_uncorr = 1'b0;
    logic       cfg_rbds = 1'b0;
    logic       cfg_acq_mode = 1'b0;
    logic       cfg_loss_mode = 1'b0;
    logic [2:0] cfg_loss_code = 3'b010;
    logic       locked;
    logic [2:0] next_offset;
    logic       lock_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    rds_sync_tracker uut (
        .clk(clk), .rst_n(rst_n), .sync_clear(sync_clear),
        .blk_valid(blk_valid), .blk_offset(blk_offset), .blk_found(blk_found),
        .blk_uncorr(blk_uncorr), .cfg_rbds(cfg_rbds), .cfg_acq_mode(cfg_acq_mode),
        .cfg_loss_mode(cfg_loss_mode), .cfg_loss_code(cfg_loss_code),
        .locked(locked), .next_offset(next_offset), .lock_pulse(lock_pulse)
    );

    function automatic logic [2:0] code_of(input int p);
        case (p % 4)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    task automatic compare(input string tag, input logic [4:0] exp);
        logic [4:0] got;
        got = {locked, next_offset, lock_pulse};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got locked=%b next=%b pulse=%b exp locked=%b next=%b pulse=%b",
                     tag, got[4], got[3:1], got[0], exp[4], exp[3:1], exp[0]);
        end
    endtask

    // monitor: one result per accepted strobe, read 2 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && blk_valid && !sync_clear) begin
                #2;
                if (exp_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL scoreboard got unexpected result exp none");
                end else begin
                    compare(tag_q.pop_front(), exp_q.pop_front());
                end
            end
        end
    end

    task automatic blk(input logic [2:0] code, input logic fnd, input logic unc,
                       input logic el, input logic [2:0] en, input logic ep,
                       input string tag);
        @(negedge clk);
        blk_offset = code;
        blk_found  = fnd;
        blk_uncorr = unc;
        blk_valid  = 1'b1;
        exp_q.push_back({el, en, ep});
        tag_q.push_back(tag);
        @(negedge clk);
        blk_valid  = 1'b0;
        blk_found  = 1'b0;
        blk_uncorr = 1'b0;
    endtask

    task automatic miss(input logic el, input logic [2:0] en, input string tag);
        blk(3'b000, 1'b0, 1'b0, el, en, 1'b0, tag);
    endtask

    task automatic clear_pulse();
        @(negedge clk);
        sync_clear = 1'b1;
        @(negedge clk);
        sync_clear = 1'b0;
    endtask

    // acquire from HUNT with A then B; prediction ends at position 2
    task automatic lock_ab(input string tag);
        clear_pulse();
        blk(3'b000, 1'b1, 1'b0, 1'b0, 3'b001, 1'b0, {tag, " seed"});
        blk(3'b001, 1'b1, 1'b0, 1'b1, 3'b010, 1'b1, {tag, " confirm"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R13 reset state", 5'b0_000_0);

        // R1 R12 acquisition with C' in third position, flywheel
        blk(3'b000, 1'b1, 1'b0, 1'b0, 3'b001, 1'b0, "R12 seed A");
        blk(3'b001, 1'b1, 1'b0, 1'b1, 3'b010, 1'b1, "R6 confirm B");
        blk(3'b011, 1'b1, 1'b0, 1'b1, 3'b100, 1'b0, "R1 C' accepted");
        blk(3'b100, 1'b1, 1'b0, 1'b1, 3'b000, 1'b0, "R12 flywheel D");
        repeat (4) @(negedge clk);
        compare("R12 idle hold", 5'b1_000_0);

        // R8 R7 default limit 5
        for (int i = 1; i <= 4; i++) miss(1'b1, code_of(i), "R8 miss below limit");
        miss(1'b0, 3'b000, "R7 fifth miss loses sync");

        // R10 pass clears run
        lock_ab("R10");
        for (int i = 1; i <= 4; i++) miss(1'b1, code_of(2 + i), "R10 first run");
        blk(3'b010, 1'b1, 1'b0, 1'b1, 3'b100, 1'b0, "R10 passing C");
        for (int i = 1; i <= 4; i++) miss(1'b1, code_of(3 + i), "R10 second run");
        miss(1'b0, 3'b000, "R10 fifth of second run");

        // R1 unused codes
        clear_pulse();
        blk(3'b000, 1'b1, 1'b0, 1'b0, 3'b001, 1'b0, "R1 seed");
        blk(3'b110, 1'b1, 1'b0, 1'b0, 3'b010, 1'b0, "R1 code 110 as gap");
        blk(3'b111, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, "R3 code 111 second gap to hunt");

        // R3 two of three
        clear_pulse();
        blk(3'b000, 1'b1, 1'b0, 1'b0, 3'b001, 1'b0, "R3 seed");
        miss(1'b0, 3'b010, "R3 gap");
        blk(3'b010, 1'b1, 1'b0, 1'b1, 3'b100, 1'b1, "R3 confirm after gap");

        // R5 reseed
        clear_pulse();
        blk(3'b000, 1'b1, 1'b0, 1'b0, 3'b001, 1'b0, "R5 seed");
        blk(3'b010, 1'b1, 1'b0, 1'b0, 3'b100, 1'b0, "R5 reseed on C");
        blk(3'b100, 1'b1, 1'b0, 1'b1, 3'b000, 1'b1, "R5 confirm D");

        // R4 consecutive rule
        cfg_acq_mode = 1'b1;
        clear_pulse();
        blk(3'b000, 1'b1, 1'b0, 1'b0, 3'b001, 1'b0, "R4 seed");
        miss(1'b0, 3'b000, "R4 gap drops to hunt");
        blk(3'b001, 1'b1, 1'b0, 1'b0, 3'b010, 1'b0, "R4 seed B");
        blk(3'b011, 1'b1, 1'b0, 1'b1, 3'b100, 1'b1, "R4 confirm C'");
        cfg_acq_mode = 1'b0;

        // R2 offset E
        clear_pulse();
        blk(3'b000, 1'b1, 1'b0, 1'b0, 3'b001, 1'b0, "R2 seed");
        blk(3'b101, 1'b1, 1'b0, 1'b0, 3'b010, 1'b0, "R2 E ignored without rbds");
        cfg_rbds = 1'b1;
        clear_pulse();
        blk(3'b101, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, "R2 E cannot seed");
        blk(3'b000, 1'b1, 1'b0, 1'b0, 3'b001, 1'b0, "R2 seed rbds");
        blk(3'b101, 1'b1, 1'b0, 1'b1, 3'b010, 1'b1, "R2 E confirms");
        blk(3'b101, 1'b1, 1'b0, 1'b1, 3'b100, 1'b0, "R2 E passes in lock");
        cfg_rbds = 1'b0;
        for (int i = 1; i <= 4; i++) blk(3'b101, 1'b1, 1'b0, 1'b1, code_of(3 + i), 1'b0, "R2 E fails without rbds");
        miss(1'b0, 3'b000, "R2 E run reaches limit");

        // R9 uncorrectable loss, limit 3
        lock_ab("R9");
        cfg_loss_mode = 1'b1;
        cfg_loss_code = 3'b000;
        blk(3'b100, 1'b1, 1'b0, 1'b1, 3'b100, 1'b0, "R9 wrong order ignored");
        blk(3'b100, 1'b1, 1'b1, 1'b1, 3'b000, 1'b0, "R9 uncorr 1");
        blk(3'b000, 1'b1, 1'b1, 1'b1, 3'b001, 1'b0, "R9 uncorr 2");
        blk(3'b001, 1'b1, 1'b0, 1'b1, 3'b010, 1'b0, "R9 corrected clears");
        blk(3'b010, 1'b1, 1'b1, 1'b1, 3'b100, 1'b0, "R9 uncorr run 1");
        blk(3'b100, 1'b1, 1'b1, 1'b1, 3'b000, 1'b0, "R9 uncorr run 2");
        blk(3'b000, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, "R9 uncorr run 3 loses");
        cfg_loss_mode = 1'b0;

        // R7 limit 16 and limit 4
        cfg_loss_code = 3'b111;
        lock_ab("R7 sixteen");
        for (int i = 1; i <= 15; i++) miss(1'b1, code_of(2 + i), "R7 below sixteen");
        miss(1'b0, 3'b000, "R7 sixteenth miss");
        cfg_loss_code = 3'b001;
        lock_ab("R7 four");
        for (int i = 1; i <= 3; i++) miss(1'b1, code_of(2 + i), "R7 below four");
        miss(1'b0, 3'b000, "R7 fourth miss");
        cfg_loss_code = 3'b010;

        // R11 clear
        lock_ab("R11");
        clear_pulse();
        compare("R11 clear unlocks", 5'b0_000_0);
        @(negedge clk);
        sync_clear = 1'b1;
        blk_offset = 3'b000; blk_found = 1'b1; blk_valid = 1'b1;
        @(negedge clk);
        blk_offset = 3'b001;
        @(negedge clk);
        blk_valid = 1'b0; blk_found = 1'b0;
        sync_clear = 1'b0;
        @(negedge clk);
        compare("R11 blocks under clear ignored", 5'b0_000_0);
        blk(3'b010, 1'b1, 1'b0, 1'b0, 3'b100, 1'b0, "R11 fresh seed after clear");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard got %0d pending exp 0", exp_q.size());
        end
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule